// File: doc/BRIEF.md
# Segmented Message Credit Retry Scheduler

This block sits on the transmit side of a serial message interface that has several transmit queues. It visits the queues in round-robin order and takes the message at the head of the first non-empty queue. It then asks for outbound credit once for each segment of that message. A segment leaves the block toward the physical-layer stub only in a cycle where credit is granted.

The number of credit attempts allowed depends on the position of the segment. The first segment gets a short budget, `FIRST_TRIES` (256 by default). If that budget runs out, the block gives up its turn without writing any status. The message stays at the head of its queue and is tried again from its first segment when the round-robin loop comes back to that queue.

Each later segment gets a long budget, `LATER_TRIES` (65536 by default). If a later segment uses up its budget, the message is cancelled, completion code 3'b111 is written for it, and it is not resent. A message whose segments are all sent gets completion code 3'b000. The message source removes a message from its queue when it sees the completion write.

Top module: `seg_credit_sched`

## Requirements
- R1: While `rst_ni` is low, `credit_req_o`, `seg_valid_o` and `cmpl_we_o` are 0. After reset, the round-robin pointer is at queue 0, so with every queue valid, queue 0 is served first.
- R2: Starting at the queue after the one served last, the block takes the first queue whose `msg_valid_i` bit is 1, and empty queues cost no attempt. A message becomes active one clock after it is picked in the idle state. With no valid queue, `credit_req_o` stays 0.
- R3: `seg_valid_o` is 1 only in a cycle where `credit_req_o` and `credit_gnt_i` are both 1. In each such cycle `credit_queue_o` names the active queue and `seg_idx_o` counts 0, 1, 2 and so on. `seg_last_o` marks the segment whose index equals the latched `seg_cnt_i` field, which holds the number of segments minus one.
- R4: In the cycle where the last segment is granted, `cmpl_we_o` is 1 with `cmpl_code_o` = 3'b000 and `cmpl_queue_o` set to the active queue. The next queue is then examined.
- R5: If the first segment sees `FIRST_TRIES` request cycles without a grant, the request drops for one cycle and no completion is written. Service then moves to the next valid queue in round-robin order.
- R6: A message that gave up its turn under R5 is retried later starting from segment index 0.
- R7: If a later segment (index of 1 or more) sees `LATER_TRIES` request cycles without a grant, `cmpl_we_o` is 1 in the last of those cycles with `cmpl_code_o` = 3'b111. No further segment of that message is sent.
- R8: Each grant clears the attempt count. Every segment therefore gets its full budget, whatever the earlier segments used.
- R9: While a message is active, `credit_queue_o` does not change and no other queue is served, even if other queues hold valid messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | NQ | One bit per queue: a message waits at the head of the queue |
| seg_cnt_i | input | NQ*SEG_W | Per-queue field holding the number of segments minus one |
| credit_req_o | output | 1 | Outbound credit request for the active segment |
| credit_queue_o | output | QW | Queue that owns the request and any granted segment |
| credit_gnt_i | input | 1 | Credit granted in this cycle |
| seg_valid_o | output | 1 | Segment handed to the physical-layer stub |
| seg_idx_o | output | SEG_W | Index of the segment within its message |
| seg_last_o | output | 1 | The active segment is the last one of its message |
| cmpl_we_o | output | 1 | Completion status write |
| cmpl_queue_o | output | QW | Queue the completion belongs to |
| cmpl_code_o | output | 3 | 3'b000 for a message fully sent, 3'b111 for a cancelled message |

## Verification
The segment output and the completion write are combinational from the grant, so they appear in the same cycle as the grant. The starvation outcomes of R5 and R7 appear in the same cycle as the last failed request. A message becomes active one clock after it is picked in the idle state.

The bench drives inputs on the falling edge and samples one time unit later, before the next rising edge. Each sample is therefore compared with the cycle that the inputs just set up. Expected request and completion cycles are counted from the configured budgets: one request cycle per attempt, plus one idle cycle after each yield.

// File: rtl/seg_credit_pkg.sv
package seg_credit_pkg;
  typedef enum logic [2:0] {
    CMPL_OK     = 3'b000,
    CMPL_CANCEL = 3'b111
  } cmpl_code_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned NQ = 4,
  localparam int unsigned QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic [NQ-1:0] req_i,
  input  logic [QW-1:0] ptr_i,
  output logic          found_o,
  output logic [QW-1:0] idx_o
);
  logic [2*NQ-1:0] dbl;
  logic [NQ-1:0]   rot;
  logic [QW:0]     off;
  logic [QW:0]     sum;

  // rotate so that bit 0 is the queue under the pointer
  always_comb begin
    dbl = {req_i, req_i} >> ptr_i;
    rot = dbl[NQ-1:0];
  end

  always_comb begin
    off = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (rot[i]) off = (QW + 1)'(i);
    end
    sum = {1'b0, ptr_i} + off;
    if (sum >= (QW + 1)'(NQ)) sum = sum - (QW + 1)'(NQ);
    found_o = |req_i;
    idx_o   = sum[QW-1:0];
  end
endmodule

// File: rtl/retry_budget.sv
module retry_budget #(
  parameter int unsigned FIRST_TRIES = 256,
  parameter int unsigned LATER_TRIES = 65536,
  localparam int unsigned CW = (LATER_TRIES > 2) ? $clog2(LATER_TRIES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic first_i,
  output logic spent_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // true on the attempt that uses up the budget
  assign spent_o = first_i ? (cnt_q == CW'(FIRST_TRIES - 1))
                           : (cnt_q == CW'(LATER_TRIES - 1));
endmodule

// File: rtl/seg_credit_sched.sv
module seg_credit_sched
  import seg_credit_pkg::*;
#(
  parameter int unsigned NQ          = 4,
  parameter int unsigned SEG_W       = 4,
  parameter int unsigned FIRST_TRIES = 256,
  parameter int unsigned LATER_TRIES = 65536,
  localparam int unsigned QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NQ-1:0]              msg_valid_i,
  input  logic [NQ-1:0][SEG_W-1:0]   seg_cnt_i,
  output logic                       credit_req_o,
  output logic [QW-1:0]              credit_queue_o,
  input  logic                       credit_gnt_i,
  output logic                       seg_valid_o,
  output logic [SEG_W-1:0]           seg_idx_o,
  output logic                       seg_last_o,
  output logic                       cmpl_we_o,
  output logic [QW-1:0]              cmpl_queue_o,
  output logic [2:0]                 cmpl_code_o
);
  logic             busy_q;
  logic [QW-1:0]    ptr_q, cur_q;
  logic [SEG_W-1:0] seg_q, last_q;
  logic             found;
  logic [QW-1:0]    pick;
  logic             spent, first_seg, starve, cancel, done_ok;
  logic [QW-1:0]    cur_nxt;

  rr_pick #(.NQ(NQ)) u_pick (
    .req_i   (msg_valid_i),
    .ptr_i   (ptr_q),
    .found_o (found),
    .idx_o   (pick)
  );

  retry_budget #(.FIRST_TRIES(FIRST_TRIES), .LATER_TRIES(LATER_TRIES)) u_budget (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!busy_q || credit_gnt_i || starve),
    .inc_i   (busy_q && !credit_gnt_i),
    .first_i (first_seg),
    .spent_o (spent)
  );

  always_comb begin
    first_seg = (seg_q == '0);
    starve    = busy_q && !credit_gnt_i && spent;
    cancel    = starve && !first_seg;
    done_ok   = busy_q && credit_gnt_i && (seg_q == last_q);
    cur_nxt   = (cur_q == QW'(NQ - 1)) ? '0 : cur_q + 1'b1;
  end

  assign credit_req_o   = busy_q;
  assign credit_queue_o = cur_q;
  assign seg_valid_o    = busy_q && credit_gnt_i;
  assign seg_idx_o      = seg_q;
  assign seg_last_o     = (seg_q == last_q);
  assign cmpl_we_o      = done_ok || cancel;
  assign cmpl_queue_o   = cur_q;
  assign cmpl_code_o    = cancel ? CMPL_CANCEL : CMPL_OK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      cur_q  <= '0;
      seg_q  <= '0;
      last_q <= '0;
    end else if (!busy_q) begin
      if (found) begin
        busy_q <= 1'b1;
        cur_q  <= pick;
        seg_q  <= '0;
        last_q <= seg_cnt_i[pick];
      end
    end else if (credit_gnt_i) begin
      if (seg_q == last_q) begin
        busy_q <= 1'b0;
        ptr_q  <= cur_nxt;
      end else begin
        seg_q  <= seg_q + 1'b1;
      end
    end else if (starve) begin
      // first segment: yield turn; later segment: cancelled
      busy_q <= 1'b0;
      ptr_q  <= cur_nxt;
    end
  end
endmodule

// File: rtl/seg_credit_sched_chk.sv
module seg_credit_sched_chk #(
  parameter int unsigned NQ    = 4,
  parameter int unsigned SEG_W = 4,
  parameter int unsigned QW    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NQ-1:0]    msg_valid_i,
  input logic             credit_req_o,
  input logic [QW-1:0]    credit_queue_o,
  input logic             credit_gnt_i,
  input logic             seg_valid_o,
  input logic [SEG_W-1:0] seg_idx_o,
  input logic             seg_last_o,
  input logic             cmpl_we_o,
  input logic [2:0]       cmpl_code_o
);
  p_seg_needs_grant_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o |-> (credit_req_o && credit_gnt_i));

  p_ok_on_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_we_o && cmpl_code_o == 3'b000) |-> (seg_valid_o && seg_last_o));

  p_cancel_on_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_we_o && cmpl_code_o == 3'b111) |-> (credit_req_o && !credit_gnt_i && seg_idx_o != '0));

  p_code_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_we_o |-> (cmpl_code_o == 3'b000 || cmpl_code_o == 3'b111));

  p_hold_queue_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_valid_o && !seg_last_o) |=> (credit_req_o && $stable(credit_queue_o)));

  p_idle_empty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|msg_valid_i) && !credit_req_o) |=> !credit_req_o);

  p_start_at_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (credit_req_o && !$past(credit_req_o)) |-> (seg_idx_o == '0));
endmodule

bind seg_credit_sched seg_credit_sched_chk #(.NQ(NQ), .SEG_W(SEG_W), .QW(QW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .msg_valid_i    (msg_valid_i),
  .credit_req_o   (credit_req_o),
  .credit_queue_o (credit_queue_o),
  .credit_gnt_i   (credit_gnt_i),
  .seg_valid_o    (seg_valid_o),
  .seg_idx_o      (seg_idx_o),
  .seg_last_o     (seg_last_o),
  .cmpl_we_o      (cmpl_we_o),
  .cmpl_code_o    (cmpl_code_o)
);

// File: tb/seg_credit_sched_test.sv
module seg_credit_sched_test;
  localparam int PERIOD = 10;
  localparam int NQ = 4;
  localparam int SEG_W = 3;
  localparam int FT = 4;
  localparam int LT = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NQ-1:0] msg_valid = '0;
  logic [NQ-1:0][SEG_W-1:0] seg_cnt = '0;
  logic credit_gnt = 1'b0;
  logic credit_req, seg_valid, seg_last, cmpl_we;
  logic [1:0] credit_queue, cmpl_queue;
  logic [SEG_W-1:0] seg_idx;
  logic [2:0] cmpl_code;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  seg_credit_sched #(.NQ(NQ), .SEG_W(SEG_W), .FIRST_TRIES(FT), .LATER_TRIES(LT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .msg_valid_i(msg_valid), .seg_cnt_i(seg_cnt),
    .credit_req_o(credit_req), .credit_queue_o(credit_queue), .credit_gnt_i(credit_gnt),
    .seg_valid_o(seg_valid), .seg_idx_o(seg_idx), .seg_last_o(seg_last),
    .cmpl_we_o(cmpl_we), .cmpl_queue_o(cmpl_queue), .cmpl_code_o(cmpl_code)
  );

  // sampled copies
  logic s_req, s_sv, s_last, s_cw;
  logic [1:0] s_rq, s_cq;
  logic [SEG_W-1:0] s_idx;
  logic [2:0] s_code;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    msg_valid = '0;
    credit_gnt = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic cycle(input logic g);
    @(negedge clk);
    credit_gnt = g;
    #1;
    s_req = credit_req; s_rq = credit_queue; s_sv = seg_valid; s_idx = seg_idx;
    s_last = seg_last; s_cw = cmpl_we; s_cq = cmpl_queue; s_code = cmpl_code;
    if (s_cw) msg_valid[s_cq] = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int segs, order_n;
    bit done, bad;
    int order [4];

    // R1: outputs quiet in reset even with stimulus applied
    rst_ni = 1'b0;
    msg_valid = '1;
    credit_gnt = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(!credit_req && !seg_valid && !cmpl_we, "R1 reset outputs", {credit_req, seg_valid, cmpl_we}, 0);

    // R3/R4: sweep every queue and every length
    for (int q = 0; q < NQ; q++) begin
      for (int n = 1; n <= 8; n++) begin
        do_reset();
        msg_valid[q] = 1'b1;
        seg_cnt[q] = SEG_W'(n - 1);
        segs = 0; done = 0;
        for (int c = 0; c < 30 && !done; c++) begin
          cycle(1'b1);
          if (s_sv) begin
            chk(s_idx == SEG_W'(segs), "R3 seg index", s_idx, segs);
            chk(s_rq == 2'(q), "R3 seg queue", s_rq, q);
            chk(s_last == (segs == n - 1), "R3 last flag", s_last, segs == n - 1);
            segs++;
          end
          if (s_cw) begin
            chk(s_code == 3'b000, "R4 ok code", s_code, 0);
            chk(s_cq == 2'(q), "R4 cmpl queue", s_cq, q);
            chk(segs == n, "R4 seg total", segs, n);
            done = 1;
          end
        end
        chk(done, "R4 completion seen", done, 1);
      end
    end

    // R1/R2: order after reset with all valid, one segment each
    do_reset();
    seg_cnt = '0;
    msg_valid = 4'b1111;
    order_n = 0;
    for (int c = 0; c < 20 && order_n < 4; c++) begin
      cycle(1'b1);
      if (s_cw) begin order[order_n] = s_cq; order_n++; end
    end
    chk(order_n == 4, "R2 four completions", order_n, 4);
    for (int i = 0; i < 4; i++) chk(order[i] == i, "R1 R2 rr order", order[i], i);

    // R2: empty queues skipped
    do_reset();
    msg_valid = 4'b1010;
    order_n = 0;
    for (int c = 0; c < 20 && order_n < 2; c++) begin
      cycle(1'b1);
      if (s_cw) begin order[order_n] = s_cq; order_n++; end
    end
    chk(order_n == 2 && order[0] == 1 && order[1] == 3, "R2 skip empty", order[0] * 10 + order[1], 13);

    // R2: wrap from pointer 3 to queue 0
    do_reset();
    msg_valid = 4'b0100;
    done = 0;
    for (int c = 0; c < 10 && !done; c++) begin
      cycle(1'b1);
      if (s_cw) done = 1;
    end
    msg_valid = 4'b1001;
    order_n = 0;
    for (int c = 0; c < 20 && order_n < 2; c++) begin
      cycle(1'b1);
      if (s_cw) begin order[order_n] = s_cq; order_n++; end
    end
    chk(order_n == 2 && order[0] == 3 && order[1] == 0, "R2 wrap order", order[0] * 10 + order[1], 30);

    // R2: idle when empty
    do_reset();
    bad = 0;
    for (int c = 0; c < 10; c++) begin
      cycle(1'b1);
      if (s_req || s_sv || s_cw) bad = 1;
    end
    chk(!bad, "R2 idle empty", bad, 0);

    // R5: first-segment starvation alternates between queues 0 and 2
    do_reset();
    seg_cnt = '0;
    seg_cnt[0] = 3'd1;
    seg_cnt[2] = 3'd1;
    msg_valid = 4'b0101;
    for (int k = 1; k <= 3 * FT + 3; k++) begin
      int ph, rnd;
      cycle(1'b0);
      ph = (k - 1) % (FT + 1);
      rnd = (k - 1) / (FT + 1);
      chk(s_req == (ph < FT), "R5 request pattern", s_req, ph < FT);
      if (ph < FT) chk(s_rq == ((rnd % 2 == 0) ? 2'd0 : 2'd2), "R5 yield queue", s_rq, (rnd % 2 == 0) ? 0 : 2);
      chk(!s_cw && !s_sv, "R5 no completion", s_cw, 0);
    end
    // R6: the next turn restarts at segment 0 of queue 2
    done = 0;
    for (int c = 0; c < 5 && !done; c++) begin
      cycle(1'b1);
      if (s_sv) begin
        chk(s_rq == 2'd2 && s_idx == '0, "R6 restart at seg 0", s_rq * 10 + s_idx, 20);
        done = 1;
      end
    end
    chk(done, "R6 retry served", done, 1);

    // R7: later-segment starvation cancels
    do_reset();
    seg_cnt[1] = 3'd2;
    msg_valid = 4'b0010;
    cycle(1'b1);
    chk(s_sv && s_idx == '0, "R7 first seg granted", s_sv, 1);
    for (int k = 2; k <= LT + 1; k++) begin
      cycle(1'b0);
      chk(s_req, "R7 still requesting", s_req, 1);
      chk(s_cw == (k == LT + 1), "R7 cancel timing", s_cw, k == LT + 1);
      if (s_cw) chk(s_code == 3'b111 && s_cq == 2'd1, "R7 cancel code", s_code, 7);
    end
    bad = 0;
    for (int c = 0; c < 8; c++) begin
      cycle(1'b1);
      if (s_sv || s_req) bad = 1;
    end
    chk(!bad, "R7 no resend", bad, 0);

    // R8/R9: near-budget misses per segment, with another queue waiting
    do_reset();
    seg_cnt[3] = 3'd2;
    seg_cnt[0] = 3'd0;
    msg_valid = 4'b1000;
    cycle(1'b0);        // pointer 0 -> picks 3 on first idle edge
    msg_valid[0] = 1'b1;
    segs = 0; done = 0; bad = 0;
    for (int s = 0; s < 3; s++) begin
      int miss;
      miss = (s == 0) ? FT - 2 : LT - 1;
      for (int m = 0; m < miss; m++) begin
        cycle(1'b0);
        if (s_cw || s_rq != 2'd3 || !s_req) bad = 1;
      end
      cycle(1'b1);
      if (s_rq != 2'd3) bad = 1;
      if (s_sv) segs++;
      if (s_cw) begin
        done = 1;
        chk(s_code == 3'b000, "R8 ok after retries", s_code, 0);
      end
    end
    chk(!bad, "R9 queue held", bad, 0);
    chk(segs == 3 && done, "R8 all segments sent", segs, 3);
    // queue 0 served afterwards
    done = 0;
    for (int c = 0; c < 5 && !done; c++) begin
      cycle(1'b1);
      if (s_cw) begin done = 1; chk(s_cq == 2'd0, "R9 next queue", s_cq, 0); end
    end
    chk(done, "R9 waiting queue served", done, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule